// File: doc/BRIEF.md
# Bus Break Address Comparator

This block watches every bus cycle and compares it against conditions programmed in two identical break channels. Each channel holds a 24-bit break address and an 8-bit control byte. The control byte selects how many low address bits to ignore, which kind of cycle counts, and which bus owner counts: the CPU alone, or the CPU and the transfer controller. When a strobed bus cycle satisfies all of a channel's conditions, that channel sets a sticky match flag. If the channel's enable bit is set, the flag requests the break interrupt.

Software clears a flag with a two-step handshake. It first reads the control byte and sees the flag at 1. It then writes the byte with bit 7 at 0. A write of 0 that was not preceded by such a read leaves the flag alone. A write of 1 never changes the flag. The break interrupt output is the OR of both channels' requests. The exception entry that responds to it, and the bus arbitration, lie outside the block.

Top module: `brk_addr_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is 0.
- R2: Register map on `reg_addr`. Address 0 is the control byte of channel A and address 1 is the control byte of channel B. Addresses 2, 3 and 4 hold channel A's break address bytes from low to high, and addresses 5, 6 and 7 hold channel B's. Control bits 6:0 and the address bytes read back as written. `reg_rdata` carries the value on the cycle after the `reg_rd` strobe and is 0 when no read was strobed.
- R3: Control bits 5:3 give the mask code. Codes 0 to 7 ignore the low 0, 1, 2, 3, 4, 8, 12 and 16 address bits respectively when the bus address is compared with the break address.
- R4: Control bits 2:1 give the cycle select. 00 matches an instruction fetch (`bus_fetch`=1). 01 matches a data read (`bus_fetch`=0, `bus_write`=0). 10 matches a data write (`bus_fetch`=0, `bus_write`=1). 11 matches either kind of data access.
- R5: Control bit 6 gives the master select, and `bus_mst` gives the bus owner: 00 is the CPU, 01 is the transfer controller, 10 and 11 are other masters. With bit 6 at 0, only a CPU cycle can match. With bit 6 at 1, a CPU cycle or a transfer controller cycle can match. Other masters never match.
- R6: The flag (control bit 7) is set by the clock edge at which `bus_vld` is 1 and the channel's conditions hold. Without `bus_vld`, the flag is not set.
- R7: A write of 1 to bit 7 never changes the flag. A write of 0 clears the flag only if the flag was read as 1 since that channel's previous control write.
- R8: If a match occurs on the same edge as a clearing write, the flag stays set.
- R9: `irq` goes to 1 one clock after any channel's flag and enable bit (bit 0) are both 1, and it falls one clock after no such channel remains.
- R10: The two channels are independent. A match on one channel does not set the other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| bus_vld | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 24 | Bus address |
| bus_fetch | input | 1 | 1 = instruction fetch |
| bus_write | input | 1 | 1 = data write |
| bus_mst | input | 2 | Bus owner code |
| irq | output | 1 | Break interrupt request |

## Verification
A strobed bus cycle sets the flag at the edge that samples it. The flag can only be seen through a read strobed after that edge, and read data appears one clock after the read strobe. `irq` follows the flag one clock later than the flag itself. The bench drives every input on a falling edge and samples results on the following falling edge. For `irq`, it samples once right after the bus cycle, where the value must still be 0, and once a cycle later, where it must be 1. This pins the one-cycle lag, and it pins the clearing side the same way.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    SEL_FETCH = 2'b00,
    SEL_READ  = 2'b01,
    SEL_WRITE = 2'b10,
    SEL_DATA  = 2'b11
  } cyc_sel_e;

  typedef enum logic [1:0] {
    MST_CPU   = 2'b00,
    MST_XFER  = 2'b01,
    MST_OTHER = 2'b10,
    MST_SPARE = 2'b11
  } mst_e;

  // Control byte: flag[7] msel[6] mcode[5:3] csel[2:1] ie[0]
  typedef struct packed {
    logic     flag;
    logic     msel;
    logic [2:0] mcode;
    cyc_sel_e csel;
    logic     ie;
  } ctl_t;

  // Number of ignored low address bits for a mask code: 0,1,2,3,4,8,12,16
  function automatic int mask_bits(input logic [2:0] code);
    int n;
    n = int'(code);
    if (n > 4) n = (n - 3) * 4;
    return n;
  endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [2:0]        mcode,
  input  cyc_sel_e          csel,
  input  logic              msel,
  input  logic [ADDR_W-1:0] bar,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_mst,
  output logic              cond
);

  logic [ADDR_W-1:0] keep;
  logic              addr_ok;
  logic              cyc_ok;
  logic              mst_ok;
  int                nb;

  always_comb begin
    nb = mask_bits(mcode);
    for (int i = 0; i < ADDR_W; i++) keep[i] = (i >= nb);
  end

  assign addr_ok = ((bus_addr ^ bar) & keep) == '0;

  always_comb begin
    unique case (csel)
      SEL_FETCH: cyc_ok = bus_fetch;
      SEL_READ:  cyc_ok = !bus_fetch && !bus_write;
      SEL_WRITE: cyc_ok = !bus_fetch && bus_write;
      default:   cyc_ok = !bus_fetch;
    endcase
  end

  assign mst_ok = (bus_mst == MST_CPU) || (msel && (bus_mst == MST_XFER));
  assign cond   = addr_ok && cyc_ok && mst_ok;

endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int ABYTES = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_re,
  input  logic [ABYTES-1:0] bar_we,
  input  logic [7:0]        wdata,
  input  logic              hit,
  output ctl_t              ctl_q,
  output logic [ADDR_W-1:0] bar_q
);

  logic seen_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      bar_q    <= '0;
      seen_one <= 1'b0;
    end else begin
      if (ctl_we) begin
        ctl_q.msel  <= wdata[6];
        ctl_q.mcode <= wdata[5:3];
        ctl_q.csel  <= cyc_sel_e'(wdata[2:1]);
        ctl_q.ie    <= wdata[0];
        seen_one    <= 1'b0;
      end else if (ctl_re && ctl_q.flag) begin
        seen_one <= 1'b1;
      end
      if (hit)
        ctl_q.flag <= 1'b1;
      else if (ctl_we && !wdata[7] && seen_one)
        ctl_q.flag <= 1'b0;
      for (int b = 0; b < ABYTES; b++)
        if (bar_we[b]) bar_q[b*8 +: 8] <= wdata;
    end
  end

  // R6: flag only rises after a qualified bus cycle
  p_set_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.flag) |-> $past(hit));

  // R7: flag only falls after a zero write that followed a read of one
  p_clear_rule_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.flag) |-> $past(ctl_we && !wdata[7] && seen_one));

  // R7: writing one to the flag keeps a set flag
  p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && wdata[7] && ctl_q.flag) |=> ctl_q.flag);

  // R8: a match always leaves the flag set, even against a clearing write
  p_hit_wins_r8: assert property (@(posedge clk) disable iff (rst)
    hit |=> ctl_q.flag);

endmodule

// File: rtl/brk_addr_unit.sv
module brk_addr_unit
  import brk_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [1:0]        bus_mst,
  output logic              irq
);

  localparam int ABYTES = ADDR_W / 8;

  ctl_t              ctl_q [NCH];
  logic [ADDR_W-1:0] bar_q [NCH];
  logic [NCH-1:0]    hit;
  logic [NCH-1:0]    pend;
  logic [7:0]        rd_mux;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              cond;
    logic [ABYTES-1:0] bwe;
    logic              cwe;
    logic              cre;

    for (genvar b = 0; b < ABYTES; b++) begin : g_byte
      assign bwe[b] = reg_wr && (reg_addr == REG_AW'(NCH + c*ABYTES + b));
    end
    assign cwe = reg_wr && (reg_addr == REG_AW'(c));
    assign cre = reg_rd && (reg_addr == REG_AW'(c));

    brk_match #(.ADDR_W(ADDR_W)) u_match (
      .mcode    (ctl_q[c].mcode),
      .csel     (ctl_q[c].csel),
      .msel     (ctl_q[c].msel),
      .bar      (bar_q[c]),
      .bus_addr (bus_addr),
      .bus_fetch(bus_fetch),
      .bus_write(bus_write),
      .bus_mst  (bus_mst),
      .cond     (cond)
    );

    assign hit[c]  = bus_vld && cond;
    assign pend[c] = ctl_q[c].flag && ctl_q[c].ie;

    brk_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .ctl_we(cwe),
      .ctl_re(cre),
      .bar_we(bwe),
      .wdata (reg_wdata),
      .hit   (hit[c]),
      .ctl_q (ctl_q[c]),
      .bar_q (bar_q[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == REG_AW'(c)) rd_mux = ctl_q[c];
      for (int b = 0; b < ABYTES; b++)
        if (reg_addr == REG_AW'(NCH + c*ABYTES + b)) rd_mux = bar_q[c][b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? rd_mux : 8'h00;
      irq       <= |pend;
    end
  end

  // R2: read data is zero on cycles without a read strobe
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == 8'h00));

  // R9: interrupt follows pending requests one cycle later
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|pend) |=> irq);
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !irq);

endmodule

// File: tb/sim_brk_addr_unit.sv
module sim_brk_addr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_vld = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_fetch = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_mst = 2'b00;
  logic        irq;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  brk_addr_unit u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_vld(bus_vld),
    .bus_addr(bus_addr), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_mst(bus_mst), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  mcode;
    logic [1:0]  csel;
    logic        msel;
    logic [23:0] bar;
    logic [23:0] addr;
    logic        fetch;
    logic        wr;
    logic [1:0]  mst;
    logic        exp;
  } vec_t;

  localparam int NV = 27;
  // Mask vectors (R3), cycle select vectors (R4), master select vectors (R5)
  localparam vec_t VECS [NV] = '{
    '{4'd3, 3'd0, 2'b01, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd0, 2'b01, 1'b0, 24'h123456, 24'h123457, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd1, 2'b01, 1'b0, 24'h123456, 24'h123457, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd1, 2'b01, 1'b0, 24'h123456, 24'h123455, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd2, 2'b01, 1'b0, 24'h123456, 24'h123455, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd3, 2'b01, 1'b0, 24'h123456, 24'h123451, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd3, 2'b01, 1'b0, 24'h123456, 24'h12345E, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd4, 2'b01, 1'b0, 24'h123456, 24'h12345F, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd4, 2'b01, 1'b0, 24'h123456, 24'h123466, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd5, 2'b01, 1'b0, 24'h123456, 24'h1234A9, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd5, 2'b01, 1'b0, 24'h123456, 24'h1235FF, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd6, 2'b01, 1'b0, 24'h123456, 24'h123FFF, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd6, 2'b01, 1'b0, 24'h123456, 24'h124456, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd3, 3'd7, 2'b01, 1'b0, 24'h123456, 24'h12ABCD, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd3, 3'd7, 2'b01, 1'b0, 24'h123456, 24'h132222, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd4, 3'd0, 2'b00, 1'b0, 24'h123456, 24'h123456, 1'b1, 1'b0, 2'b00, 1'b1},
    '{4'd4, 3'd0, 2'b00, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd4, 3'd0, 2'b01, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b1, 2'b00, 1'b0},
    '{4'd4, 3'd0, 2'b10, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b1, 2'b00, 1'b1},
    '{4'd4, 3'd0, 2'b10, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b00, 1'b0},
    '{4'd4, 3'd0, 2'b11, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd4, 3'd0, 2'b11, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b1, 2'b00, 1'b1},
    '{4'd4, 3'd0, 2'b11, 1'b0, 24'h123456, 24'h123456, 1'b1, 1'b0, 2'b00, 1'b0},
    '{4'd5, 3'd0, 2'b01, 1'b0, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b01, 1'b0},
    '{4'd5, 3'd0, 2'b01, 1'b1, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b01, 1'b1},
    '{4'd5, 3'd0, 2'b01, 1'b1, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b00, 1'b1},
    '{4'd5, 3'd0, 2'b01, 1'b1, 24'h123456, 24'h123456, 1'b0, 1'b0, 2'b10, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_bar(input int ch, input logic [23:0] v);
    for (int b = 0; b < 3; b++) reg_write(3'(2 + ch*3 + b), v[b*8 +: 8]);
  endtask

  task automatic bus_cycle(input logic [23:0] a, input logic f, input logic w, input logic [1:0] m);
    @(negedge clk); bus_vld = 1'b1; bus_addr = a; bus_fetch = f; bus_write = w; bus_mst = m;
    @(negedge clk); bus_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), d);
      check("R1", d, 0);
    end
    check("R1 irq", irq, 0);

    // R2: readback and register map
    reg_write(3'd0, 8'h7F);
    reg_read(3'd0, d); check("R2 ctlA", d, 8'h7F);
    reg_write(3'd1, 8'hFF);
    reg_read(3'd1, d); check("R7 flag write one", d, 8'h7F);
    set_bar(0, 24'hA1B2C3);
    set_bar(1, 24'h0D0E0F);
    reg_read(3'd2, d); check("R2 barA lo", d, 8'hC3);
    reg_read(3'd4, d); check("R2 barA hi", d, 8'hA1);
    reg_read(3'd6, d); check("R2 barB mid", d, 8'h0E);
    reg_write(3'd0, 8'h00);
    reg_write(3'd1, 8'h00);

    // Vector table: R3, R4, R5 on channel A
    for (int i = 0; i < NV; i++) begin
      reg_write(3'd0, {1'b0, VECS[i].msel, VECS[i].mcode, VECS[i].csel, 1'b0});
      set_bar(0, VECS[i].bar);
      bus_cycle(VECS[i].addr, VECS[i].fetch, VECS[i].wr, VECS[i].mst);
      reg_read(3'd0, d);
      nchk++;
      if (d[7] !== VECS[i].exp) begin
        nfail++;
        $display("FAIL R%0d vector %0d: got %0b expected %0b", VECS[i].req, i, d[7], VECS[i].exp);
      end
    end

    // R6: no strobe, no flag
    reg_write(3'd0, 8'h02);
    set_bar(0, 24'h123456);
    @(negedge clk); bus_addr = 24'h123456; bus_fetch = 1'b0; bus_write = 1'b0; bus_mst = 2'b00;
    @(negedge clk);
    reg_read(3'd0, d); check("R6 no strobe", d[7], 0);
    bus_cycle(24'h123456, 1'b0, 1'b0, 2'b00);
    reg_read(3'd0, d); check("R6 strobe sets", d[7], 1);

    // R7: write one keeps, write zero needs prior read
    reg_write(3'd0, 8'h82);
    reg_read(3'd0, d); check("R7 write one", d[7], 1);
    reg_write(3'd0, 8'h82);
    reg_write(3'd0, 8'h02);
    reg_read(3'd0, d); check("R7 zero without read", d[7], 1);
    reg_write(3'd0, 8'h02);
    reg_read(3'd0, d); check("R7 clear after read", d[7], 0);

    // R8: match on the same edge as the clearing write
    bus_cycle(24'h123456, 1'b0, 1'b0, 2'b00);
    reg_read(3'd0, d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h02;
    bus_vld = 1'b1; bus_addr = 24'h123456; bus_fetch = 1'b0; bus_write = 1'b0; bus_mst = 2'b00;
    @(negedge clk); reg_wr = 1'b0; bus_vld = 1'b0;
    reg_read(3'd0, d); check("R8 match wins", d[7], 1);
    reg_write(3'd0, 8'h02);
    reg_read(3'd0, d); check("R8 later clear", d[7], 0);

    // R9 / R10: channel B write break by transfer controller, interrupt on
    reg_write(3'd1, 8'h45);
    set_bar(1, 24'hABCDEF);
    bus_cycle(24'hABCDEF, 1'b0, 1'b1, 2'b01);
    check("R9 irq lag", irq, 0);
    @(negedge clk);
    check("R9 irq set", irq, 1);
    reg_read(3'd0, d); check("R10 chanA untouched", d[7], 0);
    reg_read(3'd1, d); check("R10 chanB flag", d, 8'hC5);
    reg_write(3'd1, 8'h45);
    check("R9 irq holds one cycle", irq, 1);
    @(negedge clk);
    check("R9 irq cleared", irq, 0);
    reg_write(3'd1, 8'h44);
    bus_cycle(24'hABCDEF, 1'b0, 1'b1, 2'b01);
    @(negedge clk); @(negedge clk);
    check("R9 disabled", irq, 0);
    reg_read(3'd1, d); check("R9 flag without irq", d, 8'hC4);

    finish_run();
  end

endmodule